// File: doc/BRIEF.md
# Pipelined Maximum-Direction Selector

This block takes a set of N unsigned magnitudes, one per direction, and reports which direction holds the largest value together with that value. Its typical use is the last stage of an edge detector: each direction's response to an oriented filter goes in, and the strongest response comes out as the gradient magnitude. The index of the winning direction comes out as the gradient angle.

The selection runs through a binary tree of two-input compare nodes. Each node subtracts one candidate from the other and uses the borrow to pick the larger. It then registers the winning value along with its direction index. Each tree level is one clock stage, so a new set of N values can enter on every cycle. A valid flag travels alongside the data through the same stages. When N is not a power of two, the tree is widened to the next power of two and the extra leaves carry magnitude zero.

Top module: `gtree_argmax`

## Requirements
- R1: While `rst_n` is low, and afterwards until a valid input set has travelled through the tree, `out_valid` is 0.
- R2: The latency is L = ceil(log2 N) clock cycles. `out_valid` equals `in_valid` from L cycles earlier, and a cycle with `in_valid` low produces a cycle with `out_valid` low L cycles later.
- R3: When `out_valid` is 1, `out_mag` equals the largest of the N magnitudes sampled L cycles earlier. Direction i occupies bits `in_mag[i*MAG_W +: MAG_W]`.
- R4: When `out_valid` is 1, `out_ang` is the direction index i whose slice holds the value on `out_mag`, and it is always below N.
- R5: When several directions share the largest magnitude, `out_ang` is the lowest of their indices.
- R6: A new input set is accepted on every cycle. Back-to-back sets give back-to-back results in the same order, with no stall.
- R7: Magnitudes are compared as unsigned numbers over their full range. The all-ones value beats every other value, and a value with the top bit set beats any value with the top bit clear.
- R8: When N is not a power of two, the padding leaves never win. An input set that is entirely zero gives `out_ang` = 0 and `out_mag` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every stage is updated on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of all stages |
| in_valid | input | 1 | Marks `in_mag` as a set to be evaluated this cycle |
| in_mag | input | N*MAG_W | N unsigned magnitudes; direction i occupies bits [i*MAG_W +: MAG_W] |
| out_valid | output | 1 | Marks `out_mag`/`out_ang` as a result |
| out_mag | output | MAG_W | Largest magnitude of the set |
| out_ang | output | ceil(log2 N) | Direction index of the largest magnitude |

## Verification
Every result is due exactly ceil(log2 N) rising edges after its set is presented, which is three edges for both benched widths (N = 8 and N = 5). The bench drives on the falling edge and keeps a ring of expected results L entries deep. At every falling edge, before it drives the next set, it compares the outputs with the entry written L falling edges earlier. Sets with `in_valid` low enter the ring as expected-idle entries, so bubbles are checked in the same slot as data. The checker compares each result against its own L-deep history of the inputs.

// File: rtl/gtree_pkg.sv
package gtree_pkg;

    // Number of bits needed to name one of n directions (at least one).
    function automatic int idx_width(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    // Number of registered two-input levels needed to reduce n leaves to one.
    function automatic int tree_levels(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    // Leaf count after widening n to a power of two.
    function automatic int padded_leaves(input int n);
        return 1 << tree_levels(n);
    endfunction

endpackage

// File: rtl/gtree_cmp_node.sv
module gtree_cmp_node #(
    parameter int MAG_W = 16,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [MAG_W-1:0] lo_mag,
    input  logic [IDX_W-1:0] lo_idx,
    input  logic [MAG_W-1:0] hi_mag,
    input  logic [IDX_W-1:0] hi_idx,
    output logic [MAG_W-1:0] win_mag,
    output logic [IDX_W-1:0] win_idx
);

    typedef struct packed {
        logic [MAG_W-1:0] mag;
        logic [IDX_W-1:0] idx;
    } node_t;

    node_t          node_d, node_q;
    logic [MAG_W:0] diff;
    logic           hi_wins;

    // The lower-index candidate minus the higher-index one. A borrow means the
    // higher-index candidate is strictly larger. Equal values keep the lower index.
    always_comb begin
        diff       = {1'b0, lo_mag} - {1'b0, hi_mag};
        hi_wins    = diff[MAG_W];
        node_d.mag = hi_wins ? hi_mag : lo_mag;
        node_d.idx = hi_wins ? hi_idx : lo_idx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            node_q <= '0;
        end else begin
            node_q <= node_d;
        end
    end

    assign win_mag = node_q.mag;
    assign win_idx = node_q.idx;

endmodule

// File: rtl/gtree_level.sv
module gtree_level #(
    parameter int MAG_W  = 16,
    parameter int IDX_W  = 3,
    parameter int IN_CNT = 8,
    localparam int OUT_CNT = IN_CNT / 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_vld,
    input  logic [IN_CNT*MAG_W-1:0]    in_mag,
    input  logic [IN_CNT*IDX_W-1:0]    in_idx,
    output logic                       out_vld,
    output logic [OUT_CNT*MAG_W-1:0]   out_mag,
    output logic [OUT_CNT*IDX_W-1:0]   out_idx
);

    typedef struct packed {
        logic vld;
    } lvl_t;

    lvl_t lvl_d, lvl_q;

    // Pair 2k (lower index) against 2k+1 (higher index).
    for (genvar k = 0; k < OUT_CNT; k++) begin : g_node
        gtree_cmp_node #(
            .MAG_W (MAG_W),
            .IDX_W (IDX_W)
        ) u_node (
            .clk     (clk),
            .rst_n   (rst_n),
            .lo_mag  (in_mag[(2*k)*MAG_W +: MAG_W]),
            .lo_idx  (in_idx[(2*k)*IDX_W +: IDX_W]),
            .hi_mag  (in_mag[(2*k+1)*MAG_W +: MAG_W]),
            .hi_idx  (in_idx[(2*k+1)*IDX_W +: IDX_W]),
            .win_mag (out_mag[k*MAG_W +: MAG_W]),
            .win_idx (out_idx[k*IDX_W +: IDX_W])
        );
    end

    always_comb begin
        lvl_d.vld = in_vld;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= '0;
        end else begin
            lvl_q <= lvl_d;
        end
    end

    assign out_vld = lvl_q.vld;

endmodule

// File: rtl/gtree_argmax.sv
module gtree_argmax #(
    parameter int N     = 8,
    parameter int MAG_W = 16,
    localparam int ANG_W = gtree_pkg::idx_width(N)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [N*MAG_W-1:0] in_mag,
    output logic               out_valid,
    output logic [MAG_W-1:0]   out_mag,
    output logic [ANG_W-1:0]   out_ang
);

    localparam int LEVELS = gtree_pkg::tree_levels(N);
    localparam int PADN   = gtree_pkg::padded_leaves(N);

    logic [PADN*MAG_W-1:0] leaf_mag;
    logic [PADN*ANG_W-1:0] leaf_idx;

    // Leaves: real directions first, then zero-magnitude padding whose indices
    // are all above N-1, so a padding leaf can never beat a real one on a tie.
    for (genvar i = 0; i < PADN; i++) begin : g_leaf
        if (i < N) begin : g_real
            assign leaf_mag[i*MAG_W +: MAG_W] = in_mag[i*MAG_W +: MAG_W];
        end else begin : g_pad
            assign leaf_mag[i*MAG_W +: MAG_W] = '0;
        end
        assign leaf_idx[i*ANG_W +: ANG_W] = ANG_W'(i);
    end

    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        localparam int IN_CNT  = PADN >> l;
        localparam int OUT_CNT = IN_CNT / 2;

        logic                     o_vld;
        logic [OUT_CNT*MAG_W-1:0] o_mag;
        logic [OUT_CNT*ANG_W-1:0] o_idx;

        if (l == 0) begin : g_first
            gtree_level #(
                .MAG_W  (MAG_W),
                .IDX_W  (ANG_W),
                .IN_CNT (IN_CNT)
            ) u_level (
                .clk     (clk),
                .rst_n   (rst_n),
                .in_vld  (in_valid),
                .in_mag  (leaf_mag),
                .in_idx  (leaf_idx),
                .out_vld (o_vld),
                .out_mag (o_mag),
                .out_idx (o_idx)
            );
        end else begin : g_next
            gtree_level #(
                .MAG_W  (MAG_W),
                .IDX_W  (ANG_W),
                .IN_CNT (IN_CNT)
            ) u_level (
                .clk     (clk),
                .rst_n   (rst_n),
                .in_vld  (g_lvl[l-1].o_vld),
                .in_mag  (g_lvl[l-1].o_mag),
                .in_idx  (g_lvl[l-1].o_idx),
                .out_vld (o_vld),
                .out_mag (o_mag),
                .out_idx (o_idx)
            );
        end
    end

    assign out_valid = g_lvl[LEVELS-1].o_vld;
    assign out_mag   = g_lvl[LEVELS-1].o_mag;
    assign out_ang   = g_lvl[LEVELS-1].o_idx;

endmodule

// File: rtl/gtree_argmax_chk.sv
module gtree_argmax_chk #(
    parameter int N     = 8,
    parameter int MAG_W = 16,
    localparam int ANG_W = gtree_pkg::idx_width(N)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [N*MAG_W-1:0] in_mag,
    input logic               out_valid,
    input logic [MAG_W-1:0]   out_mag,
    input logic [ANG_W-1:0]   out_ang
);

    localparam int LAT = gtree_pkg::tree_levels(N);
    localparam int CW  = $clog2(LAT + 1);

    logic [N*MAG_W-1:0] hist_q [LAT];
    logic [LAT-1:0]     vhist_q;
    logic [CW-1:0]      since_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < LAT; s++) hist_q[s] <= '0;
            vhist_q <= '0;
            since_q <= '0;
        end else begin
            hist_q[0] <= in_mag;
            for (int s = 1; s < LAT; s++) hist_q[s] <= hist_q[s-1];
            vhist_q <= {vhist_q[LAT-2:0], in_valid};
            if (since_q != CW'(LAT)) since_q <= since_q + 1'b1;
        end
    end

    logic             any_above;
    logic             earlier_tie;
    logic [MAG_W-1:0] picked;

    always_comb begin
        any_above   = 1'b0;
        earlier_tie = 1'b0;
        picked      = '0;
        for (int j = 0; j < N; j++) begin
            if (hist_q[LAT-1][j*MAG_W +: MAG_W] > out_mag) any_above = 1'b1;
            if (j < int'(out_ang) && hist_q[LAT-1][j*MAG_W +: MAG_W] == out_mag)
                earlier_tie = 1'b1;
            if (j == int'(out_ang)) picked = hist_q[LAT-1][j*MAG_W +: MAG_W];
        end
    end

    // R1
    rst_quiet_chk: assert property (@(posedge clk) !rst_n |-> !out_valid);

    // R1
    fill_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_q != CW'(LAT)) |-> !out_valid);

    // R2
    valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_q == CW'(LAT)) |-> (out_valid == vhist_q[LAT-1]));

    // R3
    max_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !any_above);

    // R4
    ang_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(out_ang) < N && picked == out_mag));

    // R5
    tie_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !earlier_tie);

endmodule

bind gtree_argmax gtree_argmax_chk #(
    .N     (N),
    .MAG_W (MAG_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_mag    (in_mag),
    .out_valid (out_valid),
    .out_mag   (out_mag),
    .out_ang   (out_ang)
);

// File: tb/gtree_argmax_bench.sv
`timescale 1ns/1ps
module gtree_argmax_bench;

    localparam int N8  = 8;
    localparam int W8  = 16;
    localparam int L8  = 3;   // ceil(log2 8)
    localparam int N5  = 5;
    localparam int W5  = 8;
    localparam int L5  = 3;   // ceil(log2 5)

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic              in_valid = 1'b0;
    logic [N8*W8-1:0]  in_mag = '0;
    logic              out_valid;
    logic [W8-1:0]     out_mag;
    logic [2:0]        out_ang;

    logic              o_in_valid = 1'b0;
    logic [N5*W5-1:0]  o_in_mag = '0;
    logic              o_out_valid;
    logic [W5-1:0]     o_out_mag;
    logic [2:0]        o_out_ang;

    gtree_argmax #(.N(N8), .MAG_W(W8)) u_gtree_argmax (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mag(in_mag),
        .out_valid(out_valid), .out_mag(out_mag), .out_ang(out_ang)
    );

    gtree_argmax #(.N(N5), .MAG_W(W5)) u_gtree_argmax_odd (
        .clk(clk), .rst_n(rst_n), .in_valid(o_in_valid), .in_mag(o_in_mag),
        .out_valid(o_out_valid), .out_mag(o_out_mag), .out_ang(o_out_ang)
    );

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic          exp_v [L8];
    logic [W8-1:0] exp_m [L8];
    logic [2:0]    exp_a [L8];
    string         exp_t [L8];
    int            n_push = 0;
    logic [31:0]   lfsr = 32'h1d2c_3b4a;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Lowest index wins a tie (strict greater-than while scanning upward).
    task automatic ref_max(input logic [N8*W8-1:0] v, output logic [W8-1:0] m,
                           output logic [2:0] a);
        m = v[W8-1:0];
        a = 3'd0;
        for (int i = 1; i < N8; i++) begin
            if (v[i*W8 +: W8] > m) begin
                m = v[i*W8 +: W8];
                a = 3'(i);
            end
        end
    endtask

    // At each falling edge: check the result of the set pushed L8 edges ago,
    // then present the next set.
    task automatic push(input logic v, input logic [N8*W8-1:0] vec, input string tag);
        int slot;
        logic [W8-1:0] m;
        logic [2:0]    a;
        @(negedge clk);
        slot = n_push % L8;
        chk(out_valid == exp_v[slot], exp_t[slot], "out_valid",
            longint'(out_valid), longint'(exp_v[slot]));
        if (exp_v[slot]) begin
            chk(out_mag == exp_m[slot], exp_t[slot], "out_mag",
                longint'(out_mag), longint'(exp_m[slot]));
            chk(out_ang == exp_a[slot], exp_t[slot], "out_ang",
                longint'(out_ang), longint'(exp_a[slot]));
        end
        in_valid = v;
        in_mag   = vec;
        ref_max(vec, m, a);
        exp_v[slot] = v;
        exp_m[slot] = m;
        exp_a[slot] = a;
        exp_t[slot] = tag;
        n_push++;
    endtask

    function automatic logic [N8*W8-1:0] one_hot_mag(input int idx, input logic [W8-1:0] big,
                                                      input logic [W8-1:0] rest);
        logic [N8*W8-1:0] v;
        for (int i = 0; i < N8; i++) v[i*W8 +: W8] = (i == idx) ? big : rest;
        return v;
    endfunction

    task automatic t_reset;
        for (int c = 0; c < L8; c++) begin
            exp_v[c] = 1'b0; exp_m[c] = '0; exp_a[c] = '0; exp_t[c] = "R1";
        end
        repeat (3) begin
            @(negedge clk);
            chk(!out_valid, "R1", "out_valid in reset", longint'(out_valid), 0);
        end
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_each_direction;
        // R3 R4 R6: every direction wins once, back to back
        for (int i = 0; i < N8; i++)
            push(1'b1, one_hot_mag(i, 16'(100 + 7*i), 16'(20 + i)), "R3/R4/R6");
    endtask

    task automatic t_ties;
        // R5: all equal -> direction 0; tie between 3 and 6 -> 3; tie 6 and 7 -> 6
        logic [N8*W8-1:0] v;
        push(1'b1, {N8{16'h0042}}, "R5");
        v = one_hot_mag(3, 16'd900, 16'd5);
        v[6*W8 +: W8] = 16'd900;
        push(1'b1, v, "R5");
        v = one_hot_mag(6, 16'd77, 16'd1);
        v[7*W8 +: W8] = 16'd77;
        push(1'b1, v, "R5");
    endtask

    task automatic t_full_scale;
        // R7: full-scale and top-bit cases
        logic [N8*W8-1:0] v;
        push(1'b1, one_hot_mag(7, 16'hFFFF, 16'h0000), "R7");
        v = one_hot_mag(2, 16'h8000, 16'h7FFF);
        push(1'b1, v, "R7");
        v = one_hot_mag(0, 16'hFFFE, 16'hFFFD);
        v[5*W8 +: W8] = 16'hFFFF;
        push(1'b1, v, "R7");
        push(1'b1, {N8{16'h0000}}, "R7");
    endtask

    task automatic t_bubbles;
        // R2: valid pattern 1,0,1,1,0,0,1 travels with fixed latency
        logic [6:0] pat = 7'b1001101;
        for (int i = 0; i < 7; i++)
            push(pat[i], one_hot_mag(i % N8, 16'(300 + i), 16'd3), "R2");
    endtask

    task automatic t_random;
        // R3 R4 R6: pseudo-random sets, every cycle
        logic [N8*W8-1:0] v;
        for (int k = 0; k < 48; k++) begin
            for (int i = 0; i < N8; i++) begin
                lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                v[i*W8 +: W8] = (k % 4 == 0) ? {12'h0, lfsr[3:0]} : lfsr[15:0];
            end
            push(1'b1, v, "R3/R4");
        end
    endtask

    task automatic t_drain;
        for (int i = 0; i < L8 + 1; i++) push(1'b0, '0, "R2");
    endtask

    task automatic odd_case(input logic [N5*W5-1:0] v, input logic [W5-1:0] em,
                            input logic [2:0] ea, input string tag);
        @(negedge clk);
        o_in_valid = 1'b1;
        o_in_mag   = v;
        @(negedge clk);
        o_in_valid = 1'b0;
        repeat (L5 - 1) @(negedge clk);
        chk(o_out_valid == 1'b1, tag, "odd out_valid", longint'(o_out_valid), 1);
        chk(o_out_mag == em, tag, "odd out_mag", longint'(o_out_mag), longint'(em));
        chk(o_out_ang == ea, tag, "odd out_ang", longint'(o_out_ang), longint'(ea));
        @(negedge clk);
        chk(o_out_valid == 1'b0, "R2", "odd out_valid after one set",
            longint'(o_out_valid), 0);
    endtask

    task automatic t_odd;
        // R8: N = 5, padding leaves must not win
        odd_case('0, 8'd0, 3'd0, "R8");
        odd_case({8'd1, 8'd0, 8'd0, 8'd0, 8'd0}, 8'd1, 3'd4, "R8");
        odd_case({N5{8'hFF}}, 8'hFF, 3'd0, "R8");
        odd_case({8'd9, 8'd200, 8'd9, 8'd199, 8'd9}, 8'd200, 3'd3, "R8");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_each_direction();
        t_ties();
        t_full_scale();
        t_bubbles();
        t_random();
        t_drain();
        t_odd();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule